// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block turns a write-only serial stream into whole bytes, each marked as either a command or display data. The host drives an active-low select, a serial clock, a serial data line and a command/data line. The block samples all of them in the system clock domain, through synchronizers and edge detection. Each completed byte appears at the outputs for exactly one system clock cycle, together with its tag.

The host frames transfers by pulling the select low. While the select is high, the receiver forgets any partial byte and ignores the serial clock. With the select held low, bytes can follow one another with no gap. An active-low asynchronous reset aborts whatever is in flight.

Top module: `ser_byte_rx`

## Requirements
- R1: While and after `rst_n` is low, `rx_vld` is 0, `rx_byte` is 0 and `rx_is_data` is 0. A byte that is partly shifted in when reset asserts produces no strobe. After reset is released with `cs_n` low, the next rising `sck` edge carries bit 7.
- R2: `sdi` is sampled on rising `sck` edges while `cs_n` is low. The first sampled bit is bit 7 (the MSB) and the eighth is bit 0.
- R3: `rx_is_data` equals the level of `dc` at the eighth rising `sck` edge of the byte: 0 marks a command byte and 1 marks a data byte. The level of `dc` during the first seven bits has no effect.
- R4: `rx_vld` is high for exactly one system clock cycle per received byte. `rx_byte` and `rx_is_data` are valid in that cycle and hold their value until the next strobe.
- R5: While `cs_n` is high, `sck` edges are ignored and the bit position returns to bit 7. After a falling `cs_n`, the next rising `sck` edge is taken as bit 7.
- R6: If `cs_n` rises before the eighth bit of a byte, the partial byte is discarded and no strobe is produced for it.
- R7: With `cs_n` held low, the rising `sck` edge after a completed byte is bit 7 of the next byte, and consecutive bytes are all delivered.
- R8: Bytes are received correctly when `sck` runs at one quarter of the system clock rate, with high and low phases of two system cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Transfer select, active low, asynchronous to clk |
| sck | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data, MSB first |
| dc | input | 1 | Command (0) / data (1) line |
| rx_vld | output | 1 | One-cycle strobe marking a completed byte |
| rx_byte | output | BYTE_W | Received byte |
| rx_is_data | output | 1 | Tag of the received byte: 1 for data, 0 for command |

## Verification
The hardest situations to reach from the ports are those where a byte is abandoned partway: a select that rises after only a few bits, and a reset pulse while bits are shifting. In both cases the only visible effect is that nothing happens. The stimulus therefore follows each abandoned fragment with a complete byte whose value differs from any mix of fragment bits and new bits. The scoreboard expects only that full byte, so any leftover bit position shows up as a wrong value or as an extra strobe. The `dc` line is also driven to the opposite level during the first seven bits of every byte, so that a tag latched too early is caught.

// File: rtl/ser_byte_rx.sv
module ser_byte_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              dc,
  output logic              rx_vld,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_is_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] cs_sy, sck_sy, sdi_sy, dc_sy;
  logic                   sck_q;
  logic [CNT_W-1:0]       cnt;
  logic [BYTE_W-2:0]      shreg;

  wire cs_s  = cs_sy[SYNC_STAGES-1];
  wire sck_s = sck_sy[SYNC_STAGES-1];
  wire sdi_s = sdi_sy[SYNC_STAGES-1];
  wire dc_s  = dc_sy[SYNC_STAGES-1];

  wire sck_rise = sck_s & ~sck_q;
  wire take     = sck_rise & ~cs_s;
  wire last     = take && (cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= '1;
      sck_sy <= '0;
      sdi_sy <= '0;
      dc_sy  <= '0;
      sck_q  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      sdi_sy <= {sdi_sy[SYNC_STAGES-2:0], sdi};
      dc_sy  <= {dc_sy[SYNC_STAGES-2:0], dc};
      sck_q  <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (cs_s) begin
      cnt <= '0;
    end else if (take) begin
      cnt   <= last ? '0 : cnt + 1'b1;
      shreg <= {shreg[BYTE_W-3:0], sdi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_vld     <= 1'b0;
      rx_byte    <= '0;
      rx_is_data <= 1'b0;
    end else begin
      rx_vld <= last;
      if (last) begin
        rx_byte    <= {shreg, sdi_s};
        rx_is_data <= dc_s;
      end
    end
  end

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |-> ($stable(rx_byte) && $stable(rx_is_data)));

  // R5
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !rx_vld);

  // R5
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0));

  // R2
  strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> $past(sck_rise));
endmodule

// File: tb/ser_byte_rx_tb.sv
`timescale 1ns/1ps
module ser_byte_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, dc = 1'b0;
  logic       rx_vld, rx_is_data;
  logic [7:0] rx_byte;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  logic [8:0] exp_q[$];
  string      req_q[$];

  always #10 clk = ~clk;

  ser_byte_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .dc(dc),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_is_data(rx_is_data)
  );

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d bytes never seen, expected 0 outstanding", req_q[0], exp_q.size());
    end
    vectors++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  // monitor: compare each strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rx_vld) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6: unexpected strobe byte=%h tag=%0d, expected none", rx_byte, rx_is_data);
      end else begin
        logic [8:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if ({rx_is_data, rx_byte} !== e) begin
          fails++;
          $display("FAIL %s: actual tag=%0d byte=%h expected tag=%0d byte=%h",
                   r, rx_is_data, rx_byte, e[8], e[7:0]);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input logic d, input int half);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = b[i];
      dc  = (i == 0) ? d : ~d;
      wait_clk(half);
      sck = 1'b1;
      wait_clk(half);
      sck = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic d, input int half, input string r);
    exp_q.push_back({d, b});
    req_q.push_back(r);
    send_bits(b, 8, d, half);
  endtask

  task automatic frame_start();
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic frame_end();
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic check_idle(input string r);
    vectors++;
    if (rx_vld !== 1'b0 || rx_byte !== 8'h00 || rx_is_data !== 1'b0) begin
      fails++;
      $display("FAIL %s: actual vld=%0d byte=%h tag=%0d expected 0/00/0",
               r, rx_vld, rx_byte, rx_is_data);
    end
  endtask

  initial begin
    wait_clk(3);
    check_idle("R1");
    rst_n = 1'b1;
    wait_clk(3);
    check_idle("R1");

    // R2 R3: command and data bytes, MSB first, dc flipped before last bit
    frame_start();
    send_byte(8'hA5, 1'b0, 4, "R2");
    frame_end();
    frame_start();
    send_byte(8'h5A, 1'b1, 4, "R3");
    frame_end();

    // R7: back-to-back bytes within one frame
    frame_start();
    send_byte(8'h01, 1'b0, 4, "R7");
    send_byte(8'h80, 1'b1, 4, "R7");
    send_byte(8'hFF, 1'b1, 4, "R7");
    send_byte(8'h00, 1'b0, 4, "R7");
    frame_end();

    // R4: after a strobe, outputs hold until the next strobe
    wait_clk(10);
    vectors++;
    if (rx_vld !== 1'b0 || rx_byte !== 8'h00 || rx_is_data !== 1'b0) begin
      fails++;
      $display("FAIL R4: actual vld=%0d byte=%h tag=%0d expected 0/00/0 held",
               rx_vld, rx_byte, rx_is_data);
    end

    // R5: sck toggling while deselected is ignored
    send_bits(8'hFF, 5, 1'b1, 4);
    frame_start();
    send_byte(8'h3C, 1'b1, 4, "R5");
    frame_end();

    // R6: partial byte dropped by deselect
    frame_start();
    send_bits(8'hFF, 5, 1'b1, 4);
    frame_end();
    frame_start();
    send_byte(8'h12, 1'b0, 4, "R6");
    frame_end();

    // R1: reset aborts a partial byte; resume with select low
    frame_start();
    send_bits(8'hFF, 4, 1'b1, 4);
    rst_n = 1'b0;
    wait_clk(3);
    check_idle("R1");
    rst_n = 1'b1;
    wait_clk(4);
    send_byte(8'h69, 1'b1, 4, "R1");
    frame_end();

    // R8: fastest serial clock, 2 high + 2 low system cycles
    frame_start();
    send_byte(8'hC3, 1'b0, 2, "R8");
    send_byte(8'h96, 1'b1, 2, "R8");
    send_byte(8'h7E, 1'b0, 2, "R8");
    frame_end();

    wait_clk(20);
    finish_run();
  end
endmodule